// File: doc/BRIEF.md
# ADC Scan Sequencer with Double-Trigger Routing

This block is the digital sequencer for a multi-channel successive-approximation converter. Software sets it up through one 16-bit control word. A scan can be launched in three ways: by the start bit, by a synchronous trigger strobe, or by a falling edge on an active-low external pin. The block then walks the enabled channels from the lowest index upwards. For each channel it issues a one-cycle request to an abstract converter and waits for that converter's done strobe. Each result is forwarded with the channel number. A routing flag says whether the result belongs in the channel's data register or in the duplication register. At the end of a scan the block raises an interrupt pulse.

Three scan modes are supported. Single mode converts the channel list once. Group mode converts list A and then list B. Continuous mode repeats the list until software stops it. In double-trigger mode a single chosen channel replaces the bitmap. Results from odd-numbered triggers are flagged for the data register and results from even-numbered triggers for the duplication register.

The controller has four states:
- IDLE waits for the start bit. Once it is set, IDLE loads the pending channel set and moves to ISSUE.
- ISSUE returns to IDLE if the start bit has been cleared. It moves to END if no channel is left. Otherwise it requests the lowest pending channel and moves to WAIT.
- WAIT returns to ISSUE on the converter's done strobe.
- END raises the interrupts, updates the start bit, the group phase and the trigger parity, and goes back to IDLE.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the control word reads 0x0000 and no request, result or interrupt is active.
- R2: Bits 5 and 11 always read 0. A write with mode code 11 leaves the stored mode unchanged. Mode codes are 00 single, 01 group and 10 continuous, held in bits [14:13].
- R3: A set start bit (bit 15) runs a scan. The scan converts every channel set in `grp_a_mask` once, in ascending order, and tags each result with its channel. In single mode bit 15 reads 0 again after the scan.
- R4: In continuous mode (10) scans repeat and bit 15 stays 1. Writing bit 15 as 0 lets the conversion in flight deliver its result and then stops all requests, with no further interrupt.
- R5: In group mode (01), list A is converted first and a scan-end pulse follows it. List B is converted next, then a group-B pulse follows if bit 6 is 1, and bit 15 clears.
- R6: Bit 9 enables trigger starts and bit 8 picks the source: 0 for `sync_trig`, 1 for the pin. A trigger is ignored while bit 9 is 0, when it comes from the unselected source, or while bit 15 is already 1.
- R7: With bits 9 and 8 set, a low pulse of two clock cycles on `ext_trig_n`, after the pin was high, is detected through a two-stage synchronizer and starts one scan.
- R8: When bit 7 is 1, the bitmaps are ignored and only the channel in bits [4:0] is converted. Odd triggers give `res_dup`=0 and even triggers give `res_dup`=1. A scan-end pulse follows only the even trigger.
- R9: The trigger parity returns to odd whenever the control word is written with bit 15 at 0, or while bit 7 is 0.
- R10: A write to bits [4:0] while bit 15 is 1 is ignored.
- R11: `scan_end_irq` is a one-cycle pulse and is raised only when bit 12 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word read data |
| grp_a_mask | input | NCH | Channel bitmap for normal scans and group A |
| grp_b_mask | input | NCH | Channel bitmap for group B |
| sync_trig | input | 1 | Synchronous trigger strobe |
| ext_trig_n | input | 1 | Asynchronous active-low trigger pin |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | CH_W | Channel of the request |
| conv_done | input | 1 | Converter done strobe |
| conv_result | input | RES_W | Converter result |
| res_valid | output | 1 | Result forward strobe |
| res_chan | output | CH_W | Channel of the forwarded result |
| res_data | output | RES_W | Forwarded result |
| res_dup | output | 1 | 1 routes the result to the duplication register |
| scan_end_irq | output | 1 | Scan-end interrupt pulse |
| grpb_end_irq | output | 1 | Group-B scan-end interrupt pulse |

## Verification
A write lands in the control word one edge after the strobe. A trigger or start bit reaches `conv_start` two edges after it is taken. A falling edge on the pin needs three edges to set the start bit, so the bench holds the pin low for two full cycles and then checks only at the end of a scan. `res_valid` is combinational with `conv_done` during WAIT. For that reason the converter model in the bench drives the strobe on the falling edge and samples `res_valid`, `res_dup` and the interrupt outputs one nanosecond later, in the same half cycle. Interrupt counts and read-back words are compared only after a settling window longer than the full scan.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_END   = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_GROUP  = 2'b01,
        MODE_CONT   = 2'b10,
        MODE_BAD    = 2'b11
    } scan_mode_e;

    localparam int B_RUN  = 15;
    localparam int B_IE   = 12;
    localparam int B_SPD  = 10;
    localparam int B_TEN  = 9;
    localparam int B_TSEL = 8;
    localparam int B_DBL  = 7;
    localparam int B_GBIE = 6;
    localparam int DCH_W  = 5;

endpackage

// File: rtl/adc_pin_edge.sv
module adc_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // idle level of the pin is high, so reset the chain high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign fall_o = last_q & ~sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/adc_lowest_pick.sv
module adc_lowest_pick #(
    parameter int NCH  = 32,
    parameter int CH_W = 5
) (
    input  logic [NCH-1:0]  mask_i,
    output logic [CH_W-1:0] idx_o,
    output logic            any_o
);
    always_comb begin
        idx_o = '0;
        any_o = |mask_i;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask_i[i]) idx_o = CH_W'(i);
        end
    end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int NCH   = 32,
    parameter int RES_W = 12,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    input  logic [NCH-1:0]   grp_a_mask,
    input  logic [NCH-1:0]   grp_b_mask,
    input  logic             sync_trig,
    input  logic             ext_trig_n,
    output logic             conv_start,
    output logic [CH_W-1:0]  conv_chan,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    output logic             res_valid,
    output logic [CH_W-1:0]  res_chan,
    output logic [RES_W-1:0] res_data,
    output logic             res_dup,
    output logic             scan_end_irq,
    output logic             grpb_end_irq
);
    seq_state_e       state_q, state_d;
    scan_mode_e       mode_q;
    logic [DCH_W-1:0] dbl_ch_q;
    logic             run_q, ie_q, spd_q, ten_q, tsel_q, dbl_q, gbie_q;
    logic             second_q, phase_b_q;
    logic [NCH-1:0]   pend_q;
    logic [CH_W-1:0]  cur_ch_q;
    logic [CH_W-1:0]  pick_idx;
    logic             pick_any;
    logic             pin_fall, trig_hit, last_part, run_drop;
    logic             unused_wbits;

    assign unused_wbits = ^{reg_wdata[11], reg_wdata[5]};

    adc_pin_edge #(.SYNC_STAGES(2)) u_pin (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_n  (ext_trig_n),
        .fall_o (pin_fall)
    );

    adc_lowest_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick (
        .mask_i (pend_q),
        .idx_o  (pick_idx),
        .any_o  (pick_any)
    );

    assign trig_hit  = ten_q & ~run_q & (tsel_q ? pin_fall : sync_trig);
    // END that finishes the whole scan (not the group-A half)
    assign last_part = (state_q == ST_END) && !(mode_q == MODE_GROUP && !phase_b_q);
    assign run_drop  = last_part && (mode_q != MODE_CONT);

    assign reg_rdata = {run_q, mode_q, ie_q, 1'b0, spd_q, ten_q, tsel_q,
                        dbl_q, gbie_q, 1'b0, dbl_ch_q};

    // control word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0; mode_q <= MODE_SINGLE; ie_q <= 1'b0; spd_q <= 1'b0;
            ten_q <= 1'b0; tsel_q <= 1'b0; dbl_q <= 1'b0; gbie_q <= 1'b0;
            dbl_ch_q <= '0;
        end else if (reg_we) begin
            run_q  <= reg_wdata[B_RUN];
            ie_q   <= reg_wdata[B_IE];
            spd_q  <= reg_wdata[B_SPD];
            ten_q  <= reg_wdata[B_TEN];
            tsel_q <= reg_wdata[B_TSEL];
            dbl_q  <= reg_wdata[B_DBL];
            gbie_q <= reg_wdata[B_GBIE];
            if (reg_wdata[14:13] != MODE_BAD) mode_q <= scan_mode_e'(reg_wdata[14:13]);
            if (!run_q) dbl_ch_q <= reg_wdata[DCH_W-1:0];
        end else if (trig_hit) begin
            run_q <= 1'b1;
        end else if (run_drop) begin
            run_q <= 1'b0;
        end
    end

    // trigger parity and group phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            second_q  <= 1'b0;
            phase_b_q <= 1'b0;
        end else begin
            if ((reg_we && !reg_wdata[B_RUN]) || !dbl_q) second_q <= 1'b0;
            else if (last_part)                          second_q <= ~second_q;
            if (state_q == ST_END) phase_b_q <= (mode_q == MODE_GROUP) && !phase_b_q;
            else if (!run_q)       phase_b_q <= 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run_q) state_d = ST_ISSUE;
            ST_ISSUE: begin
                if (!run_q)         state_d = ST_IDLE;
                else if (!pick_any) state_d = ST_END;
                else                state_d = ST_WAIT;
            end
            ST_WAIT:  if (conv_done) state_d = ST_ISSUE;
            ST_END:   state_d = ST_IDLE;
        endcase
    end

    // pending channel set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= '0;
            cur_ch_q <= '0;
        end else if (state_q == ST_IDLE && run_q) begin
            if (dbl_q)          pend_q <= {{(NCH-1){1'b0}}, 1'b1} << dbl_ch_q;
            else if (phase_b_q) pend_q <= grp_b_mask;
            else                pend_q <= grp_a_mask;
        end else if (state_q == ST_ISSUE && run_q && pick_any) begin
            pend_q[pick_idx] <= 1'b0;
            cur_ch_q         <= pick_idx;
        end
    end

    // outputs
    always_comb begin
        conv_start   = (state_q == ST_ISSUE) && run_q && pick_any;
        conv_chan    = pick_idx;
        res_valid    = (state_q == ST_WAIT) && conv_done;
        res_chan     = cur_ch_q;
        res_data     = conv_result;
        res_dup      = dbl_q & second_q;
        scan_end_irq = (state_q == ST_END) && ie_q && !phase_b_q && !(dbl_q && !second_q);
        grpb_end_irq = (state_q == ST_END) && gbie_q && phase_b_q;
    end

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
    parameter int NCH = 32,
    localparam int CH_W = $clog2(NCH)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [15:0]     reg_rdata,
    input logic            conv_start,
    input logic [CH_W-1:0] conv_chan,
    input logic            res_valid,
    input logic            res_dup,
    input logic            scan_end_irq,
    input logic            grpb_end_irq
);
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[15] |-> (reg_rdata[5] == 1'b0 && reg_rdata[11] == 1'b0));
    p_mode_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> reg_rdata[14:13] != 2'b11);
    p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    p_start_in_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> reg_rdata[15]);
    p_gb_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grpb_end_irq |-> (reg_rdata[6] && reg_rdata[14:13] == 2'b01));
    p_dup_only_dbl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_dup) |-> reg_rdata[7]);
    p_dbl_chan_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && reg_rdata[7]) |-> conv_chan == CH_W'(reg_rdata[4:0]));
    p_chan_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[15] |=> reg_rdata[4:0] == $past(reg_rdata[4:0]));
    p_irq_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        scan_end_irq |=> !scan_end_irq);
    p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        scan_end_irq |-> reg_rdata[12]);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NCH(NCH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_rdata    (reg_rdata),
    .conv_start   (conv_start),
    .conv_chan    (conv_chan),
    .res_valid    (res_valid),
    .res_dup      (res_dup),
    .scan_end_irq (scan_end_irq),
    .grpb_end_irq (grpb_end_irq)
);

// File: tb/test_adc_scan_seq.sv
`timescale 1ns/1ps
module test_adc_scan_seq;
    localparam int NCH = 32;
    localparam int RES_W = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic [NCH-1:0] grp_a_mask = '0, grp_b_mask = '0;
    logic sync_trig = 1'b0, ext_trig_n = 1'b1;
    logic conv_start, conv_done = 1'b0;
    logic [4:0] conv_chan, res_chan;
    logic [RES_W-1:0] conv_result = '0, res_data;
    logic res_valid, res_dup, scan_end_irq, grpb_end_irq;

    adc_scan_seq #(.NCH(NCH), .RES_W(RES_W)) i_adc_scan_seq (.*);

    always #5 clk = ~clk;

    int n_cmp = 0, n_bad = 0, n_res = 0, n_start = 0, n_irq = 0, n_gb = 0, cyc = 0;
    int exp_q[$];          // entries: chan*2 + dup
    bit cyc_mode = 0;
    int cyc_list[2];
    int cyc_idx = 0;
    int busy = 0, seq = 0;
    logic [4:0] req_ch;
    logic [RES_W-1:0] last_res;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // converter model and output monitor
    always @(negedge clk) begin
        bit st;
        logic [4:0] ch;
        st = conv_start; ch = conv_chan;
        conv_done = 1'b0;
        if (busy > 0) begin
            busy--;
            if (busy == 0) begin
                conv_done = 1'b1;
                conv_result = {req_ch, 7'(seq)};
                last_res = conv_result;
                seq++;
            end
        end
        if (st) begin req_ch = ch; busy = 3; n_start++; end
        #1;
        if (res_valid) begin
            int e;
            n_res++;
            if (cyc_mode) begin
                e = cyc_list[cyc_idx] * 2;
                cyc_idx = (cyc_idx + 1) % 2;
            end else if (exp_q.size() == 0) begin
                e = -1;
            end else begin
                e = exp_q.pop_front();
            end
            chk(e >= 0, "R3", "unexpected result", int'(res_chan), 0);
            if (e >= 0) begin
                chk(int'(res_chan) == e / 2, "R3", "result channel", int'(res_chan), e / 2);
                chk(int'(res_dup) == e % 2, "R8", "duplicate flag", int'(res_dup), e % 2);
            end
            chk(res_data == last_res, "R3", "result data", int'(res_data), int'(last_res));
        end
        if (scan_end_irq) n_irq++;
        if (grpb_end_irq) n_gb++;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wr(logic [15:0] v);
        @(negedge clk); reg_we = 1'b1; reg_wdata = v;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(logic [15:0] expv, string req);
        @(negedge clk); #2;
        chk(reg_rdata == expv, req, "control word", int'(reg_rdata), int'(expv));
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sync();
        @(negedge clk); sync_trig = 1'b1;
        @(negedge clk); sync_trig = 1'b0;
    endtask

    task automatic drained(string req);
        chk(exp_q.size() == 0, req, "results outstanding", exp_q.size(), 0);
    endtask

    initial begin
        int s_res, s_start;
        idle(4);
        #2 rst_n = 1'b1;
        // R1 reset state
        rd(16'h0000, "R1");
        chk(!conv_start && !res_valid && !scan_end_irq && !grpb_end_irq, "R1",
            "idle outputs", int'(conv_start), 0);

        // R2 reserved bits and illegal mode code
        wr(16'h0860); rd(16'h0040, "R2");
        wr(16'h2000); wr(16'h6000); rd(16'h2000, "R2");

        // R3 single scan, ascending, start bit self-clears; R11 gated pulse
        grp_a_mask = 32'h0000_00A4;
        exp_q = {4, 10, 14};
        n_irq = 0;
        wr(16'h9000); idle(60);
        drained("R3");
        chk(n_irq == 1, "R11", "scan-end pulses", n_irq, 1);
        rd(16'h1000, "R3");
        exp_q = {4, 10, 14};
        n_irq = 0;
        wr(16'h8000); idle(60);
        drained("R3");
        chk(n_irq == 0, "R11", "pulses with enable off", n_irq, 0);

        // R5 group scan
        grp_a_mask = 32'h1; grp_b_mask = 32'h30;
        exp_q = {0, 8, 10};
        n_irq = 0; n_gb = 0;
        wr(16'hB040); idle(80);
        drained("R5");
        chk(n_irq == 1, "R5", "group A pulses", n_irq, 1);
        chk(n_gb == 1, "R5", "group B pulses", n_gb, 1);
        rd(16'h3040, "R5");

        // R4 continuous mode, R10 frozen channel field, abort
        grp_a_mask = 32'h3;
        cyc_list[0] = 0; cyc_list[1] = 1; cyc_idx = 0; cyc_mode = 1;
        n_irq = 0;
        wr(16'hD000); idle(60);
        chk(n_irq >= 2, "R4", "repeated scans", n_irq, 2);
        rd(16'hD000, "R4");
        wr(16'hD00B); rd(16'hD000, "R10");
        wr(16'h5000); idle(30);
        s_res = n_res; s_start = n_start; n_irq = 0;
        idle(30);
        chk(n_res == s_res && n_start == s_start, "R4", "activity after stop",
            n_start - s_start, 0);
        chk(n_irq == 0, "R4", "pulses after stop", n_irq, 0);
        rd(16'h5000, "R4");
        cyc_mode = 0;

        // R6 trigger disabled, then enabled
        wr(16'h1000);
        s_res = n_res;
        pulse_sync(); idle(30);
        chk(n_res == s_res, "R6", "results with triggers off", n_res - s_res, 0);
        rd(16'h1000, "R6");
        wr(16'h1200);
        exp_q = {0, 2}; n_irq = 0;
        pulse_sync(); idle(40);
        drained("R6");
        chk(n_irq == 1, "R6", "triggered scan pulses", n_irq, 1);
        rd(16'h1200, "R6");

        // R6/R7 pin source: strobe ignored, pin edge taken
        wr(16'h1300);
        s_res = n_res;
        pulse_sync(); idle(30);
        chk(n_res == s_res, "R6", "strobe with pin source", n_res - s_res, 0);
        exp_q = {0, 2}; n_irq = 0;
        @(negedge clk); ext_trig_n = 1'b0;
        idle(2); ext_trig_n = 1'b1;
        idle(40);
        drained("R7");
        chk(n_irq == 1, "R7", "pin scan pulses", n_irq, 1);
        rd(16'h1300, "R7");

        // R8 double trigger on channel 6, bitmap ignored
        grp_a_mask = 32'hFF;
        wr(16'h1286);
        exp_q = {12}; n_irq = 0;
        pulse_sync(); idle(30);
        drained("R8");
        chk(n_irq == 0, "R8", "pulse after odd trigger", n_irq, 0);
        exp_q = {13};
        pulse_sync(); idle(30);
        drained("R8");
        chk(n_irq == 1, "R8", "pulse after even trigger", n_irq, 1);

        // R9 parity reset by a write with start at 0
        exp_q = {12};
        pulse_sync(); idle(30);
        wr(16'h1286);
        exp_q = {12}; n_irq = 0;
        pulse_sync(); idle(30);
        drained("R9");
        chk(n_irq == 0, "R9", "pulse after restart", n_irq, 0);
        exp_q = {13};
        pulse_sync(); idle(30);
        drained("R9");
        chk(n_irq == 1, "R9", "pulse after second", n_irq, 1);
        rd(16'h1286, "R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule